// File: doc/BRIEF.md
# Synchronous Decade Divider Chain

This block is a chain of synchronous BCD decade counters, all clocked by one input clock. Each stage counts 0 through 9. A stage advances only on cycles when its own count enable is active. Stage 0 takes its enable from the global count enable. Every later stage takes its enable from the terminal count of the stage below it. The chain therefore forms one higher-modulus decimal counter. With the default of three stages, the modulus is 1000.

After each decade the block also gives a divided-rate tap. The tap is a strobe one clock wide, taken once every 10, 100 and 1000 enabled cycles. From a 1 MHz clock with the enable held high, the three taps run at 100 kHz, 10 kHz and 1 kHz.

All flip-flops run on the single input clock. No clock is gated and there is no ripple clocking. The taps are intended as enables for logic downstream.

Top module: `decade_divider_chain`

## Requirements
- R1: Each stage holds a 4-bit BCD digit that stays in the range 0..9. When the stage is enabled it steps by one, and from 9 it wraps to 0. `digit_o[3:0]` is stage 0, the least significant digit. Stage k occupies `digit_o[4k+3:4k]`.
- R2: While `en_i` is low and `rst_i` is low, every digit holds its value, every `tc_o` bit is low and, one cycle later, every `tap_o` bit is low.
- R3: Stage k (k ≥ 1) advances only on a cycle when `tc_o[k-1]` is high. Its value is unchanged on every other cycle.
- R4: `tc_o[k]` is combinational. It is high exactly when the stage's enable chain is active and the stage holds 9. So `tc_o[0]` marks a low digit of 9, `tc_o[1]` marks a combined count of x99 and `tc_o[2]` marks 999, each only while `en_i` is high.
- R5: `tap_o[k]` is a registered copy of `tc_o[k]`, delayed by one clock. Under a constant enable it is high for exactly one cycle in every 10^(k+1) cycles.
- R6: A synchronous reset (`rst_i` high at a clock edge) clears all digits and taps to 0. Reset overrides `en_i`, and every `tc_o` bit is low while `rst_i` is high.
- R7: After reset, the digits read as a decimal number equal the number of enabled clock cycles modulo 10^NUM_STAGES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Single clock for all stages |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Global count enable for stage 0 |
| digit_o | output | 4*NUM_STAGES | Packed BCD digits, stage 0 in the low nibble |
| tc_o | output | NUM_STAGES | Terminal count of each stage (combinational) |
| tap_o | output | NUM_STAGES | Registered strobe, one clock wide, at each divided rate |

## Verification
The terminal counts are combinational, so they are due in the same cycle that the enable is applied. The bench samples them 1 ns after it drives `en_i` and `rst_i` on the falling edge, before the next rising edge. The digits and taps are due one rising edge after the stimulus. For each step the driver pushes the expected digits and taps into a queue, and a monitor pops and compares them 1 ns after that edge. Each comparison therefore lines up with exactly one registered update.

// File: rtl/decdiv_pkg.sv
package decdiv_pkg;

  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MOD = 10;

  typedef logic [DIGIT_W-1:0] digit_t;

  localparam digit_t DIGIT_TOP = digit_t'(DIGIT_MOD - 1);

  // Value after one enabled step, wrapping at the top digit.
  function automatic digit_t digit_step(input digit_t d);
    return (d == DIGIT_TOP) ? '0 : d + digit_t'(1);
  endfunction

  // True when the digit sits on its last legal value.
  function automatic logic digit_is_top(input digit_t d);
    return d == DIGIT_TOP;
  endfunction

endpackage

// File: rtl/decade_stage.sv
module decade_stage
  import decdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   ce_i,
  output digit_t digit_o,
  output logic   tc_o
);

  digit_t digit_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      digit_q <= '0;
    end else if (ce_i) begin
      digit_q <= digit_step(digit_q);
    end
  end

  assign digit_o = digit_q;
  assign tc_o    = ce_i & digit_is_top(digit_q);

endmodule

// File: rtl/tap_strobe.sv
module tap_strobe (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tc_i,
  output logic tap_o
);

  logic tap_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tap_q <= 1'b0;
    end else begin
      tap_q <= tc_i;
    end
  end

  assign tap_o = tap_q;

endmodule

// File: rtl/decade_divider_chain.sv
module decade_divider_chain #(
  parameter int unsigned NUM_STAGES = 3
) (
  input  logic                                      clk_i,
  input  logic                                      rst_i,
  input  logic                                      en_i,
  output logic [NUM_STAGES*decdiv_pkg::DIGIT_W-1:0] digit_o,
  output logic [NUM_STAGES-1:0]                     tc_o,
  output logic [NUM_STAGES-1:0]                     tap_o
);

  localparam int unsigned DW = decdiv_pkg::DIGIT_W;

  // Named internal events for the checker
  logic [NUM_STAGES-1:0] stage_ce;
  logic [NUM_STAGES-1:0] stage_tc;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_ce[g] = en_i & ~rst_i;
    end else begin : g_next
      assign stage_ce[g] = stage_tc[g-1];
    end

    decade_stage u_stage (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .ce_i    (stage_ce[g]),
      .digit_o (digit_o[g*DW +: DW]),
      .tc_o    (stage_tc[g])
    );

    tap_strobe u_tap (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .tc_i  (stage_tc[g]),
      .tap_o (tap_o[g])
    );
  end

  assign tc_o = stage_tc;

endmodule

// File: rtl/decdiv_checker.sv
module decdiv_checker #(
  parameter int unsigned NUM_STAGES = 3
) (
  input logic                                      clk_i,
  input logic                                      rst_i,
  input logic                                      en_i,
  input logic [NUM_STAGES*decdiv_pkg::DIGIT_W-1:0] digit_o,
  input logic [NUM_STAGES-1:0]                     tc_o,
  input logic [NUM_STAGES-1:0]                     tap_o,
  input logic [NUM_STAGES-1:0]                     stage_ce
);

  localparam int unsigned DW = decdiv_pkg::DIGIT_W;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(digit_o));

  p_no_tc_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |-> (tc_o == '0));

  p_tc_low_in_reset_r6: assert property (@(posedge clk_i)
    rst_i |-> (tc_o == '0));

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_chk
    p_digit_bcd_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      digit_o[g*DW +: DW] <= 4'd9);

    p_wrap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      tc_o[g] |=> (digit_o[g*DW +: DW] == '0));

    p_idle_stage_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !stage_ce[g] |=> $stable(digit_o[g*DW +: DW]));

    p_tc_at_nine_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      tc_o[g] |-> (digit_o[g*DW +: DW] == 4'd9) && en_i);

    p_tap_rise_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      tc_o[g] |=> tap_o[g]);

    p_tap_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      !tc_o[g] |=> !tap_o[g]);

    p_reset_clear_r6: assert property (@(posedge clk_i)
      rst_i |=> (digit_o[g*DW +: DW] == '0) && !tap_o[g]);
  end

endmodule

bind decade_divider_chain decdiv_checker #(.NUM_STAGES(NUM_STAGES)) u_decdiv_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .en_i     (en_i),
  .digit_o  (digit_o),
  .tc_o     (tc_o),
  .tap_o    (tap_o),
  .stage_ce (stage_ce)
);

// File: tb/decade_divider_chain_tb_top.sv
module decade_divider_chain_tb_top;

  typedef struct {
    logic [11:0] dig;
    logic [2:0]  tap;
    logic        en;
    logic        rst;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [11:0] digit;
  logic [2:0]  tc;
  logic [2:0]  tap;

  int checks = 0;
  int errors = 0;
  int model_n = 0;
  exp_item_t exp_q[$];

  always #2 clk = ~clk;

  decade_divider_chain #(.NUM_STAGES(3)) dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .en_i    (en),
    .digit_o (digit),
    .tc_o    (tc),
    .tap_o   (tap)
  );

  function automatic logic [11:0] to_bcd(input int n);
    return {4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic check(input logic ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: apply stimulus, check combinational terminal counts, push expectations
  task automatic step(input logic r, input logic e);
    logic [2:0] exp_tc;
    logic       ce;
    exp_item_t  it;
    @(negedge clk);
    rst = r;
    en  = e;
    #1;
    ce = e && !r;
    exp_tc[0] = ce && (model_n % 10 == 9);
    exp_tc[1] = ce && (model_n % 100 == 99);
    exp_tc[2] = ce && (model_n % 1000 == 999);
    if (r) check(tc === 3'b000, "R6 tc in reset", {9'd0, tc}, 12'd0);
    else if (!e) check(tc === 3'b000, "R2 tc idle", {9'd0, tc}, 12'd0);
    else check(tc === exp_tc, "R4 terminal count", {9'd0, tc}, {9'd0, exp_tc});
    if (r) model_n = 0;
    else if (e) model_n = (model_n + 1) % 1000;
    it.dig = to_bcd(model_n);
    it.tap = r ? 3'b000 : exp_tc;
    it.en  = e;
    it.rst = r;
    exp_q.push_back(it);
  endtask

  // Monitor: compare registered results one edge after each stimulus
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_item_t it;
      it = exp_q.pop_front();
      if (it.rst) begin
        check(digit === 12'd0, "R6 digits cleared", digit, 12'd0);
        check(tap === 3'b000, "R6 taps cleared", {9'd0, tap}, 12'd0);
      end else if (!it.en) begin
        check(digit === it.dig, "R2 digits hold", digit, it.dig);
        check(tap === 3'b000, "R2 taps idle", {9'd0, tap}, 12'd0);
      end else begin
        check(digit === it.dig, "R1 R3 R7 digit count", digit, it.dig);
        check(tap === it.tap, "R5 tap strobe", {9'd0, tap}, {9'd0, it.tap});
      end
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    // R6: reset holds everything, even with enable high
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    // R1: continuous counting through several wraps
    for (int i = 0; i < 25; i++) step(1'b0, 1'b1);
    // R2: enable low holds state
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
    // R3: alternating enable pattern
    for (int i = 0; i < 200; i++) step(1'b0, 1'(i % 2));
    // R2 R4: enable dropped while the low digit sits at 9
    while (model_n % 10 != 9) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    // R4 R5: run to 999, pause there, then roll the whole chain over
    while (model_n != 999) step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
    // R7: pseudo-random enable pattern
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(1'b0, lfsr[0]);
    end
    // R6: reset mid-run with enable high, then restart
    step(1'b1, 1'b1);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule